// File: doc/BRIEF.md
# Edge-Activated DMA Request Channel

This block is one DMA channel started by an active-low request pin from outside the chip. Software loads a source address, a destination address and a transfer count, then sets the channel's enable bit. From the clock edge after that write, the channel samples the request pin on every rising edge. When it sees a low level while acceptance is open, it holds the request, asks for the shared bus, and waits for a grant. It then performs one single-beat read from the source address and one single-beat write of that data to the destination address.

A held low level starts only one transfer. The channel accepts a new request only after it has sampled the pin high. A high seen during the read or write cycle re-opens acceptance once the write cycle ends, so back-to-back transfers are possible. A high seen later, while idle, re-opens acceptance from that edge. After each transfer both addresses advance by a fixed step and the count drops by one. When the count reaches zero the channel disables itself.

Top module: `edge_dma_channel`

## Requirements
- R1: While reset is applied and in the first cycle after it, bus_req, mem_rd and mem_wr are low and the channel is disabled.
- R2: The register write port selects a register with cfg_sel: 0 = control (cfg_wdata bit 0 is the enable bit), 1 = source address, 2 = destination address, 3 = transfer count. A low level on req_n has no effect while the channel is disabled. After the write that sets enable, the first rising edge that samples req_n low latches the request. bus_req is high in the cycle after that edge, and not in the cycle right after the enabling write.
- R3: bus_req stays high without any memory cycle until bus_gnt is sampled high. The cycle after that edge is a read cycle: mem_rd is high and mem_addr is the source address. The next cycle is a write cycle: mem_wr is high, mem_addr is the destination address, and mem_wdata equals the data read. mem_rd and mem_wr are never high together. With bus_gnt held high, latch, request, read and write take 4 cycles.
- R4: bus_req is high from the cycle after the latch through the write cycle, and low in the cycle after the write.
- R5: A req_n low level held without any high sample starts exactly one transfer.
- R6: If req_n is sampled high during the request, read or write cycle of a transfer and is low again in the first idle cycle, that low sample latches a new request, giving back-to-back transfers.
- R7: If req_n stays low through a whole transfer, a later high sample taken while idle re-opens acceptance, and the next low sample latches a request.
- R8: After each transfer the source and destination addresses each increase by STEP (default 1), and the count decreases by one.
- R9: When a transfer brings the count to zero, the enable bit clears and later low levels on req_n start no transfer.
- R10: A control write that sets enable while the count is zero leaves the channel disabled. Once a non-zero count is loaded and enable is written again, transfers resume from the incremented addresses.
- R11: A control write that clears enable while a request waits for its grant withdraws the request: bus_req falls in the second cycle after that write, and no memory cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | ADDR_W | Register write data; bit 0 is enable for the control register |
| req_n | input | 1 | Active-low external transfer request |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Single-beat read cycle |
| mem_wr | output | 1 | Single-beat write cycle |
| mem_addr | output | ADDR_W | Address of the current read or write |
| mem_wdata | output | DATA_W | Write data, the value held from the read |
| mem_rdata | input | DATA_W | Read data, captured at the end of the read cycle |

## Verification
The assertions check the shape of each transfer on every cycle. A read only follows a sampled grant, a write always follows a read, and read and write never overlap. Write data equals the value read in the cycle before, the bus request covers both memory cycles and falls right after the write, and every rise of the bus request is preceded by a low request sample. The bench's scenarios show what depends on history across transfers: that a held low starts only one transfer, when acceptance re-opens for high samples taken inside or after a transfer, address stepping, self-disable at a zero count, and the effect of enable writes.

// File: rtl/edge_dma_pkg.sv
package edge_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } xfer_st_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_SRC   = 2'd1;
    localparam logic [1:0] SEL_DST   = 2'd2;
    localparam logic [1:0] SEL_COUNT = 2'd3;

endpackage

// File: rtl/edma_cfg_regs.sv
module edma_cfg_regs
    import edge_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xfer_done,
    output logic              chan_en,
    output logic              en_set,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);
    localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic en_set_d;

    always_comb begin
        cfg_d    = cfg_q;
        en_set_d = 1'b0;
        // completed transfer: step both pointers, count down, stop at zero
        if (xfer_done) begin
            cfg_d.src = cfg_q.src + STEP_A;
            cfg_d.dst = cfg_q.dst + STEP_A;
            cfg_d.cnt = cfg_q.cnt - ONE_C;
            if (cfg_q.cnt == ONE_C) begin
                cfg_d.en = 1'b0;
            end
        end
        // software writes take precedence over the automatic update
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    if (cfg_wdata[0]) begin
                        if (cfg_q.cnt != '0) begin
                            cfg_d.en = 1'b1;
                            en_set_d = 1'b1;
                        end
                    end else begin
                        cfg_d.en = 1'b0;
                    end
                end
                SEL_SRC:   cfg_d.src = cfg_wdata;
                SEL_DST:   cfg_d.dst = cfg_wdata;
                default:   cfg_d.cnt = cfg_wdata[CNT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign chan_en  = cfg_q.en;
    assign en_set   = en_set_d;
    assign src_addr = cfg_q.src;
    assign dst_addr = cfg_q.dst;

endmodule

// File: rtl/edma_req_sampler.sv
module edma_req_sampler
    import edge_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     chan_en,
    input  logic     en_set,
    input  logic     req_n,
    input  xfer_st_e xfer_st,
    output logic     req_latch
);

    typedef struct packed {
        logic armed;
        logic hi_seen;
    } smp_t;

    smp_t smp_d, smp_q;
    logic latch_c;

    // a low sample is taken only when enabled, idle and acceptance is open
    assign latch_c = chan_en && smp_q.armed && (xfer_st == ST_IDLE) && !req_n;

    always_comb begin
        smp_d = smp_q;
        case (xfer_st)
            ST_IDLE: begin
                if (!smp_q.armed && req_n) begin
                    smp_d.armed = 1'b1;
                end
                if (latch_c) begin
                    smp_d.armed   = 1'b0;
                    smp_d.hi_seen = 1'b0;
                end
            end
            ST_REQ, ST_READ: begin
                if (req_n) begin
                    smp_d.hi_seen = 1'b1;
                end
            end
            default: begin
                // end of write: re-open only if a high level was observed
                smp_d.armed   = smp_q.hi_seen | req_n;
                smp_d.hi_seen = 1'b0;
            end
        endcase
        if (en_set) begin
            smp_d.armed   = 1'b1;
            smp_d.hi_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign req_latch = latch_c;

endmodule

// File: rtl/edma_xfer_fsm.sv
module edma_xfer_fsm
    import edge_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              req_latch,
    input  logic              bus_gnt,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output xfer_st_e          xfer_st,
    output logic              xfer_done,
    output logic              bus_req,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        xfer_st_e          st;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_IDLE: begin
                if (req_latch) begin
                    fsm_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!chan_en) begin
                    fsm_d.st = ST_IDLE;
                end else if (bus_gnt) begin
                    fsm_d.st = ST_READ;
                end
            end
            ST_READ: begin
                fsm_d.data = mem_rdata;
                fsm_d.st   = ST_WRITE;
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, data: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign xfer_st   = fsm_q.st;
    assign xfer_done = (fsm_q.st == ST_WRITE);
    assign bus_req   = (fsm_q.st != ST_IDLE);
    assign mem_rd    = (fsm_q.st == ST_READ);
    assign mem_wr    = (fsm_q.st == ST_WRITE);
    assign mem_wdata = fsm_q.data;

    always_comb begin
        case (fsm_q.st)
            ST_READ:  mem_addr = src_addr;
            ST_WRITE: mem_addr = dst_addr;
            default:  mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/edge_dma_channel.sv
module edge_dma_channel
    import edge_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_n,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              chan_en;
    logic              en_set;
    logic              req_latch;
    logic              xfer_done;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    xfer_st_e          xfer_st;

    edma_cfg_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .STEP   (STEP)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .xfer_done (xfer_done),
        .chan_en   (chan_en),
        .en_set    (en_set),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    edma_req_sampler smp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .en_set    (en_set),
        .req_n     (req_n),
        .xfer_st   (xfer_st),
        .req_latch (req_latch)
    );

    edma_xfer_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .req_latch (req_latch),
        .bus_gnt   (bus_gnt),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .mem_rdata (mem_rdata),
        .xfer_st   (xfer_st),
        .xfer_done (xfer_done),
        .bus_req   (bus_req),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/edma_chk.sv
module edma_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] mem_wdata
);

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R3
    rd_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ($past(bus_gnt) && $past(bus_req)));

    // R3
    wdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));

    // R4
    busy_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_req);

    // R4
    release_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !bus_req);

    // R2
    req_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(req_n));

endmodule

bind edge_dma_channel edma_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata)
);

// File: tb/edge_dma_channel_tb_top.sv
`timescale 1ns/1ps
module edge_dma_channel_tb_top;

    localparam logic [15:0] PAT = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic        req_n = 1'b1;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [15:0] last_wr_addr = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // memory model: read data is a fixed function of the address
    assign mem_rdata = mem_addr ^ PAT;

    edge_dma_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req_n     (req_n),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            wr_cnt++;
            last_wr_addr = mem_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
        cfg_write(2'd1, s);
        cfg_write(2'd2, d);
        cfg_write(2'd3, n);
        cfg_write(2'd0, 16'h0001);
    endtask

    // one low sample, then high; returns in the cycle after the latch edge
    task automatic pulse_req();
        @(negedge clk); req_n = 1'b0;
        @(negedge clk); req_n = 1'b1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(bus_req == 0 && mem_rd == 0 && mem_wr == 0, "R1", "outputs in reset",
            {bus_req, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        req_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_req == 0, "R1", "disabled after reset ignores low req", bus_req, 0);
        req_n = 1'b1;
    endtask

    task automatic test_basic();
        setup(16'h0100, 16'h0200, 16'd4);
        chk(bus_req == 0, "R2", "no request before low sample", bus_req, 0);
        pulse_req();
        chk(bus_req == 1, "R2", "bus_req after latch", bus_req, 1);
        @(negedge clk);
        chk(mem_rd == 1 && mem_addr == 16'h0100, "R3", "read cycle at source",
            mem_addr, 16'h0100);
        @(negedge clk);
        chk(mem_wr == 1 && mem_addr == 16'h0200, "R3", "write cycle at destination",
            mem_addr, 16'h0200);
        chk(mem_wdata == (16'h0100 ^ PAT), "R3", "write data equals read data",
            mem_wdata, 16'h0100 ^ PAT);
        @(negedge clk);
        chk(bus_req == 0 && mem_wr == 0, "R4", "bus released after write", bus_req, 0);
    endtask

    task automatic test_hold_low();
        int w0 = wr_cnt;
        @(negedge clk); req_n = 1'b0;
        repeat (12) @(negedge clk);
        req_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_cnt - w0 == 1, "R5", "held low gives one transfer", wr_cnt - w0, 1);
        chk(last_wr_addr == 16'h0201, "R8", "second destination stepped",
            last_wr_addr, 16'h0201);
    endtask

    task automatic test_back_to_back();
        int w0 = wr_cnt;
        @(negedge clk); req_n = 1'b0;
        @(negedge clk);
        @(negedge clk); req_n = 1'b1;
        chk(mem_rd == 1 && mem_addr == 16'h0102, "R8", "third source stepped",
            mem_addr, 16'h0102);
        @(negedge clk); req_n = 1'b0;
        @(negedge clk);
        chk(bus_req == 0, "R4", "idle cycle between transfers", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1, "R6", "back-to-back request latched", bus_req, 1);
        repeat (4) @(negedge clk);
        req_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(wr_cnt - w0 == 2, "R6", "two transfers", wr_cnt - w0, 2);
        chk(last_wr_addr == 16'h0203, "R8", "fourth destination", last_wr_addr, 16'h0203);
    endtask

    task automatic test_count_zero();
        int w0 = wr_cnt;
        pulse_req();
        chk(bus_req == 0, "R9", "no request after count exhausted", bus_req, 0);
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0, "R9", "no transfer after count exhausted", wr_cnt - w0, 0);
    endtask

    task automatic test_enable_zero();
        int w0 = wr_cnt;
        cfg_write(2'd0, 16'h0001);
        pulse_req();
        chk(bus_req == 0, "R10", "enable with zero count stays off", bus_req, 0);
        repeat (3) @(negedge clk);
        chk(wr_cnt == w0, "R10", "no transfer with zero count", wr_cnt - w0, 0);
        cfg_write(2'd3, 16'd1);
        cfg_write(2'd0, 16'h0001);
        pulse_req();
        chk(bus_req == 1, "R10", "re-enabled channel requests", bus_req, 1);
        @(negedge clk);
        chk(mem_rd == 1 && mem_addr == 16'h0104, "R10", "source resumes stepped",
            mem_addr, 16'h0104);
        @(negedge clk);
        chk(mem_wr == 1 && mem_addr == 16'h0204, "R8", "destination resumes stepped",
            mem_addr, 16'h0204);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_late_high();
        int w0;
        setup(16'h0300, 16'h0400, 16'd5);
        w0 = wr_cnt;
        @(negedge clk); req_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(wr_cnt - w0 == 1, "R7", "low through transfer gives one", wr_cnt - w0, 1);
        chk(bus_req == 0, "R7", "no re-accept without high", bus_req, 0);
        req_n = 1'b1;
        @(negedge clk); req_n = 1'b0;
        @(negedge clk);
        chk(bus_req == 1, "R7", "idle high sample re-opens acceptance", bus_req, 1);
        req_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(wr_cnt - w0 == 2, "R7", "second transfer done", wr_cnt - w0, 2);
    endtask

    task automatic test_grant_wait();
        bus_gnt = 1'b0;
        pulse_req();
        repeat (3) begin
            @(negedge clk);
            chk(bus_req == 1 && mem_rd == 0, "R3", "waits for grant",
                {bus_req, mem_rd}, 2'b10);
        end
        bus_gnt = 1'b1;
        @(negedge clk);
        chk(mem_rd == 1 && mem_addr == 16'h0302, "R3", "read after grant",
            mem_addr, 16'h0302);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_disable();
        int w0 = wr_cnt;
        bus_gnt = 1'b0;
        pulse_req();
        chk(bus_req == 1, "R11", "request pending", bus_req, 1);
        cfg_write(2'd0, 16'h0000);
        @(negedge clk);
        chk(bus_req == 0, "R11", "request withdrawn on disable", bus_req, 0);
        bus_gnt = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_cnt == w0, "R11", "no transfer after withdraw", wr_cnt - w0, 0);
    endtask

    task automatic test_before_enable();
        req_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(bus_req == 0, "R2", "low ignored while disabled", bus_req, 0);
        cfg_write(2'd0, 16'h0001);
        chk(bus_req == 0, "R2", "no latch on enabling edge", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1, "R2", "latch on first edge after enable", bus_req, 1);
        req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_hold_low();
        test_back_to_back();
        test_count_zero();
        test_enable_zero();
        test_late_high();
        test_grant_wait();
        test_disable();
        test_before_enable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule